// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter Stage

This block is one digit of a synchronous up-counter. Every state bit is held in a register that updates on the same rising clock edge, so all outputs change together. A digit can be forced to zero, loaded in parallel from a data input, advanced by one, or held. Two separate enables control counting: a local run enable and a chain enable. Only the chain enable gates the carry output, so a digit's carry never depends on the local run enable.

Parameters select the modulus (16 for binary digits, 10 for decade digits). They also select whether the active-low clear acts at once or on the next rising edge. To build a wider counter, tie all digits to one clock and one run enable. Each digit's carry output drives the chain enable of the digit above it. A higher digit then advances only on the cycle when every lower digit is at its last code, and no extra gating is needed.

Priority, from highest to lowest, is: clear, load, count, hold. In decade mode a digit loaded with a code from 10 to 15 keeps stepping up by one until it passes 15 and wraps to 0. It never raises its carry on the way.

Top module: `count_stage`

## Requirements
- R1: With clear and load inactive and both `run_en` and `chain_en` high at a rising edge, `count_q` becomes the previous count plus one after that edge.
- R2: With clear and load inactive and either enable low at a rising edge, `count_q` keeps its value. Only the enable levels at the rising edge matter; pulses on the enables between edges have no effect.
- R3: With `preset_n` low and clear inactive at a rising edge, `count_q` takes `preset_val` after that edge, whatever the enable levels.
- R4: With `ASYNC_WIPE` = 0, `wipe_n` low at a rising edge sets `count_q` to zero after that edge, over load and enables. Before that edge the count is unchanged.
- R5: With `ASYNC_WIPE` = 1, `wipe_n` low sets `count_q` to zero at once, with no clock edge needed, and holds it at zero while low.
- R6: `chain_out` is high exactly when `chain_en` is high and `count_q` equals MODULUS-1. It is combinational and does not depend on `run_en`.
- R7: A counting step from MODULUS-1 gives 0: 15 wraps to 0 when MODULUS=16, and 9 wraps to 0 when MODULUS=10.
- R8: With MODULUS=10, a digit loaded with 10 to 15 steps through 11, 12 and so on up to 15, then wraps to 0. `chain_out` stays low for all of these codes.
- R9: In a chain (digit k's `chain_out` drives digit k+1's `chain_en`), a digit advances only on cycles when every lower digit is at MODULUS-1. Three binary digits therefore wrap from 0xFFF to 0x000, and two decade digits wrap from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| wipe_n | input | 1 | Active-low clear; timing set by ASYNC_WIPE |
| preset_n | input | 1 | Active-low synchronous parallel load |
| preset_val | input | WIDTH | Value loaded when preset_n is low |
| run_en | input | 1 | Local count enable; does not affect chain_out |
| chain_en | input | 1 | Chain count enable; also gates chain_out |
| count_q | output | WIDTH | Current count |
| chain_out | output | 1 | High when chain_en is high and the count is at MODULUS-1 |

## Verification
The bench drives a chain of three binary digits with synchronous clear and a chain of two decade digits with asynchronous clear. It compares both chains every cycle against a per-digit behavioural model. It targets these corner cases, each with the failure a faulty design would show:
- Wraps at 0xFFF and 99: a digit that ignores its lower neighbour's carry jumps early.
- A decade digit loaded with 12: a design that treats every code of 9 or more as terminal clears too soon, or carries into the next digit.
- A clear dropped in the middle of a count: a design with the wrong clear timing zeroes the asynchronous chain one edge late, or the synchronous chain one edge early.
- Short pulses on the run enable between edges: a level-sensitive design would lose counts.

// File: rtl/cstage_pkg.sv
// Package for the counter stage.
// Holds the per-edge action chosen by the control decoder.
// Assumes: it is shared by every module of the stage and by nothing outside it.
package cstage_pkg;

    // What the state register does at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_WIPE = 2'd3
    } stage_act_e;

endpackage

// File: rtl/cstage_ctrl.sv
// Control decoder for one counter digit.
// Picks one action per edge in fixed priority: clear, load, step, hold.
// Assumes: when the clear is asynchronous the register handles it,
// so this decoder considers the clear only in synchronous mode.
module cstage_ctrl
    import cstage_pkg::*;
#(
    parameter bit SYNC_WIPE = 1'b1
) (
    input  logic       wipe_n,
    input  logic       preset_n,
    input  logic       run_en,
    input  logic       chain_en,
    output stage_act_e act
);

    localparam bit WIPE_HERE = SYNC_WIPE;

    // Priority decode of the per-edge action.
    always_comb begin
        if (WIPE_HERE && !wipe_n) begin
            act = ACT_WIPE;
        end else if (!preset_n) begin
            act = ACT_LOAD;
        end else if (run_en && chain_en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/cstage_next.sv
// Next-state datapath for one counter digit.
// Returns zero, the preset value, the count plus one with a wrap, or the
// current count.
// Assumes: 2 <= MODULUS <= 2**WIDTH. The wrap to zero happens at
// MODULUS-1. Codes above it (reachable only by load) step up until the
// width overflows to zero.
module cstage_next
    import cstage_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 16
) (
    input  stage_act_e       act,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] LAST_CODE = WIDTH'(MODULUS - 1);

    logic [WIDTH-1:0] stepped;

    // Increment with wrap at the last code of the modulus.
    always_comb begin
        if (cur == LAST_CODE) begin
            stepped = '0;
        end else begin
            stepped = cur + 1'b1;
        end
    end

    // Select the value the register takes at the next edge.
    always_comb begin
        unique case (act)
            ACT_WIPE: nxt = '0;
            ACT_LOAD: nxt = load_val;
            ACT_STEP: nxt = stepped;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cstage_reg.sv
// State register for one counter digit. All bits clock together on the
// rising edge.
// A parameter selects an asynchronous clear input or a synchronous one.
// Assumes: in synchronous mode the decoder has already folded the clear
// into nxt. The gate here is a second, equivalent guard.
module cstage_reg #(
    parameter int WIDTH      = 4,
    parameter bit ASYNC_WIPE = 1'b0
) (
    input  logic             clk,
    input  logic             wipe_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    generate
        if (ASYNC_WIPE) begin : g_async
            // Register with the clear acting at once, independent of the clock.
            always_ff @(posedge clk or negedge wipe_n) begin
                if (!wipe_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end else begin : g_sync
            // Register with the clear sampled only on the rising edge.
            always_ff @(posedge clk) begin
                if (!wipe_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cstage_term.sv
// Last-code detector and carry gate for one counter digit.
// Assumes: the carry is combinational, gated by the chain enable only
// and never by the local run enable.
module cstage_term #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 16
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             chain_en,
    output logic             chain_out
);

    localparam logic [WIDTH-1:0] LAST_CODE = WIDTH'(MODULUS - 1);

    logic at_last;

    // Detect the last code of the modulus.
    always_comb at_last = (cur == LAST_CODE);

    // Pass the chain enable on as the carry when at the last code.
    always_comb chain_out = chain_en & at_last;

endmodule

// File: rtl/count_stage.sv
// One digit of a synchronous, presettable up-counter that can be chained.
// Priority is clear, then load, then count (both enables high), then hold.
// The carry is raised when the chain enable is high and the digit is at
// MODULUS-1.
// Assumes: every digit of a chain shares clk, wipe_n, preset_n and run_en.
// Digit k's chain_out feeds digit k+1's chain_en.
module count_stage
    import cstage_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int MODULUS    = 16,
    parameter bit ASYNC_WIPE = 1'b0
) (
    input  logic             clk,
    input  logic             wipe_n,
    input  logic             preset_n,
    input  logic [WIDTH-1:0] preset_val,
    input  logic             run_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] count_q,
    output logic             chain_out
);

    localparam bit SYNC_WIPE = !ASYNC_WIPE;

    // Elaboration guard on the modulus range.
    generate
        if (MODULUS < 2 || MODULUS > (1 << WIDTH)) begin : g_bad_modulus
            $error("count_stage: MODULUS must lie in 2..2**WIDTH");
        end
    endgenerate

    stage_act_e       act;
    logic [WIDTH-1:0] nxt;

    cstage_ctrl #(
        .SYNC_WIPE (SYNC_WIPE)
    ) ctrl_i (
        .wipe_n   (wipe_n),
        .preset_n (preset_n),
        .run_en   (run_en),
        .chain_en (chain_en),
        .act      (act)
    );

    cstage_next #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) next_i (
        .act      (act),
        .cur      (count_q),
        .load_val (preset_val),
        .nxt      (nxt)
    );

    cstage_reg #(
        .WIDTH      (WIDTH),
        .ASYNC_WIPE (ASYNC_WIPE)
    ) reg_i (
        .clk    (clk),
        .wipe_n (wipe_n),
        .nxt    (nxt),
        .q      (count_q)
    );

    cstage_term #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) term_i (
        .cur       (count_q),
        .chain_en  (chain_en),
        .chain_out (chain_out)
    );

endmodule

// File: rtl/count_stage_chk.sv
// Property checker for count_stage, bound to every instance.
// Relates the count across edges and the carry to the count and the enables.
// Assumes: the inputs are stable around the rising edge.
module count_stage_chk #(
    parameter int WIDTH      = 4,
    parameter int MODULUS    = 16,
    parameter bit ASYNC_WIPE = 1'b0
) (
    input logic             clk,
    input logic             wipe_n,
    input logic             preset_n,
    input logic [WIDTH-1:0] preset_val,
    input logic             run_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] count_q,
    input logic             chain_out
);

    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(MODULUS - 1);

    logic [WIDTH-1:0] plus_one;
    always_comb plus_one = (count_q == LAST_V) ? '0 : WIDTH'(count_q + 1'b1);

    // R1 R7 R8
    count_step_chk: assert property (@(posedge clk) disable iff (!wipe_n)
        (preset_n && run_en && chain_en) |=> (count_q == $past(plus_one)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!wipe_n)
        (preset_n && !(run_en && chain_en)) |=> $stable(count_q));

    // R3
    preset_take_chk: assert property (@(posedge clk) disable iff (!wipe_n)
        !preset_n |=> (count_q == $past(preset_val)));

    // R4 R5
    wipe_zero_chk: assert property (@(posedge clk)
        !wipe_n |=> (count_q == '0));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!wipe_n)
        !chain_en |-> !chain_out);

    // R6 R8
    carry_code_chk: assert property (@(posedge clk) disable iff (!wipe_n)
        chain_out |-> (count_q == LAST_V));

endmodule

bind count_stage count_stage_chk #(
    .WIDTH      (WIDTH),
    .MODULUS    (MODULUS),
    .ASYNC_WIPE (ASYNC_WIPE)
) chk_i (.*);

// File: tb/count_stage_tb_top.sv
`timescale 1ns/1ps
// Bench: chain A is three binary digits with synchronous clear. Chain B is
// two decade digits with asynchronous clear. Both run against a per-digit
// behavioural model and are compared every cycle at the falling edge.
module count_stage_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        wipe_n   = 1'b0;
    logic        preset_n = 1'b1;
    logic        run      = 1'b0;
    logic        chen     = 1'b0;
    logic [11:0] a_val    = '0;
    logic [7:0]  b_val    = '0;
    logic [11:0] a_q;
    logic [7:0]  b_q;
    logic [3:0]  a_cy;
    logic [2:0]  b_cy;

    assign a_cy[0] = chen;
    assign b_cy[0] = chen;

    for (genvar k = 0; k < 3; k++) begin : g_bin
        count_stage #(.WIDTH(4), .MODULUS(16), .ASYNC_WIPE(1'b0)) dut_i (
            .clk(clk), .wipe_n(wipe_n), .preset_n(preset_n),
            .preset_val(a_val[4*k +: 4]), .run_en(run), .chain_en(a_cy[k]),
            .count_q(a_q[4*k +: 4]), .chain_out(a_cy[k+1]));
    end

    for (genvar k = 0; k < 2; k++) begin : g_dec
        count_stage #(.WIDTH(4), .MODULUS(10), .ASYNC_WIPE(1'b1)) dut_i (
            .clk(clk), .wipe_n(wipe_n), .preset_n(preset_n),
            .preset_val(b_val[4*k +: 4]), .run_en(run), .chain_en(b_cy[k]),
            .count_q(b_q[4*k +: 4]), .chain_out(b_cy[k+1]));
    end

    int    ma [3];
    int    mb [2];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    chk_on  = 1'b0;
    bit    done    = 1'b0;
    string cur_req = "R4 R5 reset state";

    initial begin
        foreach (ma[i]) ma[i] = 0;
        foreach (mb[i]) mb[i] = 0;
    end

    // Model of chain A: the clear is seen only at the rising edge.
    always @(posedge clk) begin
        bit c;
        bit nc;
        if (!wipe_n) begin
            foreach (ma[i]) ma[i] = 0;
        end else if (!preset_n) begin
            foreach (ma[i]) ma[i] = int'(a_val[4*i +: 4]);
        end else begin
            c = chen;
            for (int i = 0; i < 3; i++) begin
                nc = c && (ma[i] == 15);
                if (run && c) ma[i] = (ma[i] == 15) ? 0 : ma[i] + 1;
                c = nc;
            end
        end
    end

    // Model of chain B: the clear acts the moment it falls.
    always @(posedge clk or negedge wipe_n) begin
        bit c;
        bit nc;
        if (!wipe_n) begin
            foreach (mb[i]) mb[i] = 0;
        end else if (!preset_n) begin
            foreach (mb[i]) mb[i] = int'(b_val[4*i +: 4]);
        end else begin
            c = chen;
            for (int i = 0; i < 2; i++) begin
                nc = c && (mb[i] == 9);
                if (run && c) mb[i] = (mb[i] == 9) ? 0 : ((mb[i] + 1) % 16);
                c = nc;
            end
        end
    end

    // Compare both chains (counts and carries) against the model.
    always @(negedge clk) begin
        logic [11:0] ea;
        logic [3:0]  eac;
        logic [7:0]  eb;
        logic [2:0]  ebc;
        if (chk_on) begin
            eac[0] = chen;
            for (int i = 0; i < 3; i++) begin
                ea[4*i +: 4] = 4'(ma[i]);
                eac[i+1]     = eac[i] && (ma[i] == 15);
            end
            ebc[0] = chen;
            for (int i = 0; i < 2; i++) begin
                eb[4*i +: 4] = 4'(mb[i]);
                ebc[i+1]     = ebc[i] && (mb[i] == 9);
            end
            n_tests++;
            if (a_q !== ea || a_cy !== eac) begin
                n_fail++;
                $display("FAIL %s binary chain: got q=%h cy=%b, expected q=%h cy=%b",
                         cur_req, a_q, a_cy, ea, eac);
            end
            n_tests++;
            if (b_q !== eb || b_cy !== ebc) begin
                n_fail++;
                $display("FAIL %s decade chain: got q=%h cy=%b, expected q=%h cy=%b",
                         cur_req, b_q, b_cy, eb, ebc);
            end
        end
    end

    // Advance n rising edges; inputs change 1 ns after the last edge.
    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected end of test");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(2);
        chk_on = 1'b1;
        wait_cyc(2);

        cur_req = "R1 R7 R9 counting from zero";
        wipe_n = 1'b1; run = 1'b1; chen = 1'b1;
        wait_cyc(20);

        cur_req = "R2 R6 run low holds, carry follows chain enable";
        run = 1'b0;
        wait_cyc(3);

        cur_req = "R2 R6 chain enable low holds, carry low";
        run = 1'b1; chen = 1'b0;
        wait_cyc(3);

        cur_req = "R2 only the enable level at the edge matters";
        chen = 1'b1;
        for (int i = 0; i < 4; i++) begin
            run = 1'b0;
            #2;
            run = 1'b1;
            wait_cyc(1);
        end

        cur_req = "R3 load with enables low";
        run = 1'b0; chen = 1'b0; preset_n = 1'b0;
        a_val = 12'hFFD; b_val = 8'h98;
        wait_cyc(1);

        cur_req = "R7 R9 chain wrap 0xFFF and 99";
        preset_n = 1'b1; run = 1'b1; chen = 1'b1;
        wait_cyc(6);

        cur_req = "R3 R8 load wins over counting";
        preset_n = 1'b0; a_val = 12'h0F0; b_val = 8'h9C;
        wait_cyc(1);

        cur_req = "R8 decade digit above 9 steps to 15 then 0, no carry";
        preset_n = 1'b1;
        wait_cyc(6);

        cur_req = "R4 R5 clear mid-count, over load";
        wipe_n = 1'b0; preset_n = 1'b0;
        wait_cyc(2);

        cur_req = "R1 R9 counting after clear";
        wipe_n = 1'b1; preset_n = 1'b1;
        wait_cyc(14);

        chk_on = 1'b0;
        done   = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule